// File: doc/BRIEF.md
# One-hot address Wishbone interconnect

This block joins a single Wishbone classic master to a fixed number of Wishbone slaves. The master address is split into two parts. The low part is an offset that every slave receives unchanged. Above it sits a select field with one bit per slave, so slave `i` is reached by setting select bit `i`. Decoding is a priority pick over the select field: the lowest-numbered set bit wins. An access with no select bit set is refused with an error. Only the chosen slave sees its strobe. The chosen slave's read data, ack and err are steered back to the master, and all the other slaves' return signals are ignored.

The parameter `REG_OUT` chooses between two builds. With `REG_OUT = 0` the whole fabric is combinational, and a slave's response reaches the master in the same cycle as the request. With `REG_OUT = 1` the request bus is registered after the decode. A small controller then holds that registered request until the slave terminates it. This breaks the long path to slaves that sit far from the master, and each transfer costs exactly one extra cycle.

Top module: `bitsel_bus_fabric`

## Requirements
- R1: Setting only select bit `i` (master address bit `OFF_W + i`) drives `sStb[i]` and `sCyc[i]` high and leaves every other slave's strobe low; no more than one `sStb` bit is ever high.
- R2: When several select bits are set, only the slave on the lowest-numbered set bit is strobed and answers.
- R3: The selected slave receives master address bits `[OFF_W-1:0]` on `sAdr`, with the select field stripped, and receives the master's write enable and write data unchanged.
- R4: The master's `mDatR`, `mAck` and `mErr` come from the selected slave alone. A slave that answers with err produces `mErr` high and `mAck` low.
- R5: A request with all select bits zero strobes no slave and is answered with `mErr`. In registered mode, `mErr` is high for exactly one cycle.
- R6: With `REG_OUT = 0`, the slave request and the master response appear in the same cycle in which the master presents the request.
- R7: With `REG_OUT = 1`, the slave sees the request one cycle after the master presents it, and `mAck`/`mErr` reach the master one cycle later than in combinational mode. In the cycle after the slave terminates the access, the slave's strobe is low, so the request is never issued twice.
- R8: While `mCyc` is low, no slave is strobed and `mAck` and `mErr` stay low, even if `mStb` is high.
- R9: While `rst` is high, the registered build strobes no slave and gives no response, whatever the master drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mCyc | input | 1 | Master bus cycle |
| mStb | input | 1 | Master strobe |
| mWe | input | 1 | Master write enable |
| mAdr | input | OFF_W+NUM_SLV | Master address: select field above the offset |
| mDatW | input | DATA_W | Master write data |
| mDatR | output | DATA_W | Read data from the selected slave |
| mAck | output | 1 | Acknowledge to the master |
| mErr | output | 1 | Error termination to the master |
| sCyc | output | NUM_SLV | Per-slave bus cycle |
| sStb | output | NUM_SLV | Per-slave strobe |
| sWe | output | 1 | Write enable shared by all slaves |
| sAdr | output | OFF_W | Offset address shared by all slaves |
| sDatW | output | DATA_W | Write data shared by all slaves |
| sDatR | input | NUM_SLV*DATA_W | Slave read data, slave `i` in bits `[i*DATA_W +: DATA_W]` |
| sAck | input | NUM_SLV | Per-slave acknowledge |
| sErr | input | NUM_SLV | Per-slave error |

## Verification
The bench builds two copies with the default four slaves, an 8-bit offset and 32-bit data, one with `REG_OUT = 0` and one with `REG_OUT = 1`. Both copies are driven by the same master. This lets every transfer compare the same-cycle answer against the answer one cycle later, which is the whole of the latency contract. The modelled slave on the top select bit always answers with err. This brings the err-steering path into reach beside the no-select refusal, and select patterns with several bits set exercise the priority.

// File: rtl/bitsel_pkg.sv
package bitsel_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic live;     // an access is open toward the picked slave
    logic load;     // capture the master request into the slave registers
    logic clear;    // drop the registered slave strobes
    logic errNone;  // refuse the request: no select bit set
  } fabStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_FAULT = 2'd2
  } fabState_t;

endpackage

// File: rtl/bitsel_ctrl.sv
module bitsel_ctrl
  import bitsel_pkg::*;
#(
  parameter int NUM_SLV = 4,
  parameter bit REG_OUT = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mCyc,
  input  logic               mStb,
  input  logic [NUM_SLV-1:0] selField,
  input  logic [NUM_SLV-1:0] slvAck,
  input  logic [NUM_SLV-1:0] slvErr,
  output logic [NUM_SLV-1:0] reqPick,
  output logic [NUM_SLV-1:0] activePick,
  output fabStrobes_t        strobes
);

  logic [NUM_SLV-1:0] lowerSeen;
  logic               anySel;
  logic               reqNow;

  // Priority pick: a bit wins only if no lower select bit is set
  assign lowerSeen[0] = 1'b0;
  assign reqPick[0]   = selField[0];
  for (genvar i = 1; i < NUM_SLV; i++) begin : g_prio
    assign lowerSeen[i] = lowerSeen[i-1] | selField[i-1];
    assign reqPick[i]   = selField[i] & ~lowerSeen[i];
  end

  assign anySel = |selField;
  assign reqNow = mCyc & mStb;

  if (REG_OUT == 1'b0) begin : g_comb
    always_comb begin
      strobes         = '0;
      strobes.live    = reqNow & anySel;
      strobes.errNone = reqNow & ~anySel;
    end
    assign activePick = reqPick;
  end else begin : g_reg
    fabState_t          state, nextState;
    logic [NUM_SLV-1:0] pickReg;
    logic               done;

    assign done = |((slvAck | slvErr) & pickReg);

    always_comb begin
      nextState = state;
      strobes   = '0;
      case (state)
        ST_IDLE: begin
          if (reqNow) begin
            if (anySel) begin
              strobes.load = 1'b1;
              nextState    = ST_BUSY;
            end else begin
              nextState    = ST_FAULT;
            end
          end
        end
        ST_BUSY: begin
          strobes.live = 1'b1;
          if (!mCyc || done) begin
            strobes.clear = 1'b1;
            nextState     = ST_IDLE;
          end
        end
        ST_FAULT: begin
          strobes.errNone = 1'b1;
          nextState       = ST_IDLE;
        end
        default: nextState = ST_IDLE;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        state   <= ST_IDLE;
        pickReg <= '0;
      end else begin
        state <= nextState;
        if (strobes.load) pickReg <= reqPick;
      end
    end

    assign activePick = pickReg;

    // R5: the refusal lasts a single cycle
    assert_fault_single_R5: assert property (@(posedge clk) disable iff (rst)
      strobes.errNone |=> !strobes.errNone);

    // R7: once the slave terminates, the open access closes next cycle
    assert_release_after_done_R7: assert property (@(posedge clk) disable iff (rst)
      (strobes.live && done) |=> !strobes.live);
  end

  // R4: a picked slave may only answer while an access is open toward it
  assert_resp_needs_live_R4: assert property (@(posedge clk) disable iff (rst)
    (mCyc && |((slvAck | slvErr) & activePick)) |-> strobes.live);

endmodule

// File: rtl/bitsel_datapath.sv
module bitsel_datapath
  import bitsel_pkg::*;
#(
  parameter int NUM_SLV = 4,
  parameter int OFF_W   = 8,
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  fabStrobes_t               strobes,
  input  logic [NUM_SLV-1:0]        reqPick,
  input  logic [NUM_SLV-1:0]        activePick,
  input  logic                      mCyc,
  input  logic                      mWe,
  input  logic [OFF_W-1:0]          mOff,
  input  logic [DATA_W-1:0]         mDatW,
  output logic [DATA_W-1:0]         mDatR,
  output logic                      mAck,
  output logic                      mErr,
  output logic [NUM_SLV-1:0]        sCyc,
  output logic [NUM_SLV-1:0]        sStb,
  output logic                      sWe,
  output logic [OFF_W-1:0]          sAdr,
  output logic [DATA_W-1:0]         sDatW,
  input  logic [NUM_SLV*DATA_W-1:0] sDatR,
  input  logic [NUM_SLV-1:0]        sAck,
  input  logic [NUM_SLV-1:0]        sErr
);

  logic [NUM_SLV-1:0] hit;

  if (REG_OUT == 1'b0) begin : g_comb
    assign sCyc  = {NUM_SLV{mCyc}} & reqPick;
    assign sStb  = {NUM_SLV{strobes.live}} & reqPick;
    assign sWe   = mWe;
    assign sAdr  = mOff;
    assign sDatW = mDatW;
  end else begin : g_reg
    logic [NUM_SLV-1:0] cycR, stbR;
    logic               weR;
    logic [OFF_W-1:0]   adrR;
    logic [DATA_W-1:0]  datR;

    always_ff @(posedge clk) begin
      if (rst) begin
        cycR <= '0;
        stbR <= '0;
        weR  <= 1'b0;
        adrR <= '0;
        datR <= '0;
      end else if (strobes.load) begin
        cycR <= reqPick;
        stbR <= reqPick;
        weR  <= mWe;
        adrR <= mOff;
        datR <= mDatW;
      end else if (strobes.clear) begin
        cycR <= '0;
        stbR <= '0;
      end
    end

    assign sCyc  = cycR;
    assign sStb  = stbR;
    assign sWe   = weR;
    assign sAdr  = adrR;
    assign sDatW = datR;

    // R7: a registered request is held steady until it is released
    assert_request_stable_R7: assert property (@(posedge clk) disable iff (rst)
      (|stbR && !strobes.clear) |=> ($stable(adrR) && $stable(stbR) && $stable(datR)));
  end

  // Response steering from the picked slave only
  assign hit = activePick & {NUM_SLV{strobes.live}};

  always_comb begin
    mDatR = '0;
    for (int i = 0; i < NUM_SLV; i++) begin
      mDatR = mDatR | ({DATA_W{hit[i]}} & sDatR[i*DATA_W +: DATA_W]);
    end
  end

  assign mAck = mCyc & |(sAck & hit);
  assign mErr = mCyc & (|(sErr & hit) | strobes.errNone);

  // R1: at most one slave strobed
  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sStb));

  // R8: no termination without a bus cycle
  assert_no_resp_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !mCyc |-> !(mAck || mErr));

  // R5: a refused request strobes nothing
  assert_refusal_no_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.errNone |-> (sStb == '0));

  // R7: a capture starts from quiet slave strobes, a release ends a live one
  assert_load_starts_clean_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.load |-> (sStb == '0));
  assert_clear_has_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.clear |-> (|sStb));

endmodule

// File: rtl/bitsel_bus_fabric.sv
module bitsel_bus_fabric
  import bitsel_pkg::*;
#(
  parameter int NUM_SLV = 4,
  parameter int OFF_W   = 8,
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      mCyc,
  input  logic                      mStb,
  input  logic                      mWe,
  input  logic [OFF_W+NUM_SLV-1:0]  mAdr,
  input  logic [DATA_W-1:0]         mDatW,
  output logic [DATA_W-1:0]         mDatR,
  output logic                      mAck,
  output logic                      mErr,
  output logic [NUM_SLV-1:0]        sCyc,
  output logic [NUM_SLV-1:0]        sStb,
  output logic                      sWe,
  output logic [OFF_W-1:0]          sAdr,
  output logic [DATA_W-1:0]         sDatW,
  input  logic [NUM_SLV*DATA_W-1:0] sDatR,
  input  logic [NUM_SLV-1:0]        sAck,
  input  logic [NUM_SLV-1:0]        sErr
);

  localparam int ADR_W = OFF_W + NUM_SLV;

  logic [NUM_SLV-1:0] selField;
  logic [OFF_W-1:0]   mOff;
  logic [NUM_SLV-1:0] reqPick;
  logic [NUM_SLV-1:0] activePick;
  fabStrobes_t        strobes;

  assign selField = mAdr[ADR_W-1:OFF_W];
  assign mOff     = mAdr[OFF_W-1:0];

  bitsel_ctrl #(
    .NUM_SLV(NUM_SLV),
    .REG_OUT(REG_OUT)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mCyc      (mCyc),
    .mStb      (mStb),
    .selField  (selField),
    .slvAck    (sAck),
    .slvErr    (sErr),
    .reqPick   (reqPick),
    .activePick(activePick),
    .strobes   (strobes)
  );

  bitsel_datapath #(
    .NUM_SLV(NUM_SLV),
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W),
    .REG_OUT(REG_OUT)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .reqPick   (reqPick),
    .activePick(activePick),
    .mCyc      (mCyc),
    .mWe       (mWe),
    .mOff      (mOff),
    .mDatW     (mDatW),
    .mDatR     (mDatR),
    .mAck      (mAck),
    .mErr      (mErr),
    .sCyc      (sCyc),
    .sStb      (sStb),
    .sWe       (sWe),
    .sAdr      (sAdr),
    .sDatW     (sDatW),
    .sDatR     (sDatR),
    .sAck      (sAck),
    .sErr      (sErr)
  );

endmodule

// File: tb/bitsel_bus_fabric_test.sv
`timescale 1ns/1ps
module bitsel_bus_fabric_test;

  localparam int NS   = 4;
  localparam int OW   = 8;
  localparam int DW   = 32;
  localparam int AW   = OW + NS;
  localparam int ERRS = NS - 1;   // modelled slave that always answers with err

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          mCyc = 1'b0, mStb = 1'b0, mWe = 1'b0;
  logic [AW-1:0] mAdr = '0;
  logic [DW-1:0] mDatW = '0;

  logic [DW-1:0]    mDatR0, mDatR1;
  logic             mAck0, mAck1, mErr0, mErr1;
  logic [NS-1:0]    sCyc0, sCyc1, sStb0, sStb1, sAck0, sAck1, sErr0, sErr1;
  logic             sWe0, sWe1;
  logic [OW-1:0]    sAdr0, sAdr1;
  logic [DW-1:0]    sDatW0, sDatW1;
  logic [NS*DW-1:0] sDatR0, sDatR1;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  function automatic logic [DW-1:0] slvData(input int k, input logic [OW-1:0] a);
    logic [7:0] kb;
    kb = 8'(k);
    return {8'hA5, kb, 8'h3C, a};
  endfunction

  function automatic logic [NS-1:0] expPick(input logic [NS-1:0] sel);
    for (int i = 0; i < NS; i++) begin
      if (sel[i]) return NS'(1) << i;
    end
    return '0;
  endfunction

  function automatic int pickIdx(input logic [NS-1:0] pk);
    for (int i = 0; i < NS; i++) begin
      if (pk[i]) return i;
    end
    return -1;
  endfunction

  // Slave models: answer combinationally while strobed
  for (genvar k = 0; k < NS; k++) begin : g_slv
    assign sDatR0[k*DW +: DW] = slvData(k, sAdr0);
    assign sDatR1[k*DW +: DW] = slvData(k, sAdr1);
    assign sAck0[k] = sStb0[k] && (k != ERRS);
    assign sErr0[k] = sStb0[k] && (k == ERRS);
    assign sAck1[k] = sStb1[k] && (k != ERRS);
    assign sErr1[k] = sStb1[k] && (k == ERRS);
  end

  bitsel_bus_fabric #(.NUM_SLV(NS), .OFF_W(OW), .DATA_W(DW), .REG_OUT(1'b0)) uut (
    .clk(clk), .rst(rst), .mCyc(mCyc), .mStb(mStb), .mWe(mWe), .mAdr(mAdr),
    .mDatW(mDatW), .mDatR(mDatR0), .mAck(mAck0), .mErr(mErr0),
    .sCyc(sCyc0), .sStb(sStb0), .sWe(sWe0), .sAdr(sAdr0), .sDatW(sDatW0),
    .sDatR(sDatR0), .sAck(sAck0), .sErr(sErr0));

  bitsel_bus_fabric #(.NUM_SLV(NS), .OFF_W(OW), .DATA_W(DW), .REG_OUT(1'b1)) uutReg (
    .clk(clk), .rst(rst), .mCyc(mCyc), .mStb(mStb), .mWe(mWe), .mAdr(mAdr),
    .mDatW(mDatW), .mDatR(mDatR1), .mAck(mAck1), .mErr(mErr1),
    .sCyc(sCyc1), .sStb(sStb1), .sWe(sWe1), .sAdr(sAdr1), .sDatW(sDatW1),
    .sDatR(sDatR1), .sAck(sAck1), .sErr(sErr1));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic doXfer(input logic [AW-1:0] adr, input logic we, input logic [DW-1:0] wd);
    logic [NS-1:0] sel, pk;
    logic          none, expAck, expErr;
    int            idx;
    string         selTag;
    sel    = adr[AW-1:OW];
    pk     = expPick(sel);
    none   = (pk == '0);
    idx    = pickIdx(pk);
    expAck = !none && (idx != ERRS);
    expErr = none || (idx == ERRS);
    selTag = ($countones(sel) > 1) ? "R2" : "R1";

    @(negedge clk);
    mCyc = 1'b1; mStb = 1'b1; mWe = we; mAdr = adr; mDatW = wd;
    #2;
    // Combinational copy: same-cycle answer (R6)
    chk(sStb0 == pk, selTag, 64'(sStb0), 64'(pk));
    chk(sCyc0 == pk, "R1", 64'(sCyc0), 64'(pk));
    if (!none) begin
      chk(sAdr0 == adr[OW-1:0], "R3", 64'(sAdr0), 64'(adr[OW-1:0]));
      chk(sWe0 == we && sDatW0 == wd, "R3", {31'd0, sWe0, sDatW0}, {31'd0, we, wd});
    end
    chk(mAck0 == expAck, "R6", 64'(mAck0), 64'(expAck));
    chk(mErr0 == expErr, none ? "R5" : "R4", 64'(mErr0), 64'(expErr));
    if (expAck && !we) chk(mDatR0 == slvData(idx, adr[OW-1:0]), "R4", 64'(mDatR0), 64'(slvData(idx, adr[OW-1:0])));
    // Registered copy: nothing yet (R7)
    chk(sStb1 == '0 && !mAck1 && !mErr1, "R7", {59'd0, mAck1, mErr1, sStb1}, 64'd0);

    @(negedge clk);
    chk(sStb1 == pk, (selTag == "R2") ? "R2" : "R7", 64'(sStb1), 64'(pk));
    if (!none) begin
      chk(sAdr1 == adr[OW-1:0], "R3", 64'(sAdr1), 64'(adr[OW-1:0]));
      chk(sWe1 == we && sDatW1 == wd, "R3", {31'd0, sWe1, sDatW1}, {31'd0, we, wd});
    end
    chk(mAck1 == expAck, "R7", 64'(mAck1), 64'(expAck));
    chk(mErr1 == expErr, none ? "R5" : "R4", 64'(mErr1), 64'(expErr));
    if (expAck && !we) chk(mDatR1 == slvData(idx, adr[OW-1:0]), "R4", 64'(mDatR1), 64'(slvData(idx, adr[OW-1:0])));
    mCyc = 1'b0; mStb = 1'b0; mWe = 1'b0;

    @(negedge clk);
    chk(sStb1 == '0, "R7", 64'(sStb1), 64'd0);
    chk(!mAck1 && !mErr1, none ? "R5" : "R7", {62'd0, mAck1, mErr1}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R9: request asserted during reset is not issued by the registered copy
    @(negedge clk);
    mCyc = 1'b1; mStb = 1'b1; mAdr = {4'b0001, 8'h11};
    repeat (3) @(negedge clk);
    chk(sStb1 == '0 && !mAck1 && !mErr1, "R9", {59'd0, mAck1, mErr1, sStb1}, 64'd0);
    mCyc = 1'b0; mStb = 1'b0; mAdr = '0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sStb1 == '0 && sStb0 == '0 && !mAck1 && !mErr1, "R9", {55'd0, mAck1, mErr1, sStb1, sStb0}, 64'd0);

    // Directed: each slave alone, read and write
    for (int i = 0; i < NS; i++) begin
      doXfer({NS'(1) << i, 8'(8'h20 + i)}, 1'b0, 32'h0);
      doXfer({NS'(1) << i, 8'(8'hC0 + i)}, 1'b1, 32'hDEAD_0000 + i);
    end
    // R2: several select bits
    doXfer({4'b1010, 8'h5A}, 1'b0, 32'h0);
    doXfer({4'b1100, 8'hA5}, 1'b0, 32'h0);
    doXfer({4'b1111, 8'hFF}, 1'b1, 32'h1234_5678);
    doXfer({4'b0110, 8'h00}, 1'b0, 32'h0);
    // R5: no select bit
    doXfer({4'b0000, 8'h77}, 1'b0, 32'h0);
    doXfer({4'b0000, 8'h00}, 1'b1, 32'hFFFF_FFFF);

    // R8: strobe without a bus cycle
    @(negedge clk);
    mCyc = 1'b0; mStb = 1'b1; mAdr = {4'b0001, 8'h42};
    #2;
    chk(sStb0 == '0 && !mAck0 && !mErr0, "R8", {59'd0, mAck0, mErr0, sStb0}, 64'd0);
    @(negedge clk);
    chk(sStb1 == '0 && !mAck1 && !mErr1, "R8", {59'd0, mAck1, mErr1, sStb1}, 64'd0);
    mStb = 1'b0;

    // Random transfers
    for (int n = 0; n < 200; n++) begin
      logic [AW-1:0] ra;
      logic          rw;
      logic [DW-1:0] rd;
      ra = AW'($urandom);
      rw = 1'($urandom);
      rd = $urandom;
      doXfer(ra, rw, rd);
    end

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule